// File: doc/BRIEF.md
# Chained Configuration Stream Header Parser

This block is the serial front end of one device in a chain of devices that share a single configuration bit stream. It samples serial data on the rising edge of the configuration clock, searches for a fixed 12-bit start pattern, and then captures a 24-bit count that gives the total number of configuration clocks needed by the whole chain. The bits that follow are the device's own frame data. They are presented on a write strobe with a bit index, one per clock, until the local frame store holds `FRAME_BITS` bits.

Serial data out changes on the falling edge. The start pattern and the count are repeated downstream exactly as received. While the device absorbs its own frames, it drives a constant high downstream. After its store is full, it passes every further bit through to the next device. A free-running clock count starts at the first bit of the start pattern. When the local store is full and that count equals the captured total, the block raises a sticky match output. This output tells the start-up logic to begin.

Top module: `chain_hdr_rx`

## Requirements
- R1: While reset is held, and at the first sample after it, `dout` is 1, `fr_we` is 0 and `len_match` is 0.
- R2: The start pattern is 1111_1111_0010, taken first bit first. Leading ones are ignored. A mismatching bit restarts the search, and no frame write happens before a complete pattern has been seen.
- R3: The 24 bits that follow the start pattern are captured as the total clock count, most significant bit first.
- R4: Bits received before and during the header (start pattern and count) appear on `dout` unchanged. Each one appears at the falling edge that follows the rising edge that sampled it.
- R5: The `FRAME_BITS` bits after the header each produce one `fr_we` pulse, with `fr_bit` equal to the sampled bit and `fr_idx` rising from 0 in steps of 1. `dout` is 1 for each of these bits.
- R6: Once the local store is full, `fr_we` stays 0 and every further input bit is passed to `dout` unchanged.
- R7: The clock count includes the first bit of the start pattern. `len_match` rises after the rising edge of bit number N (counted from 1 at the first pattern bit), where N is the captured count, provided the store is full by then. When N equals 36 + `FRAME_BITS`, the match rises in the same cycle as the last frame write.
- R8: `len_match` stays high until reset. If N is smaller than 36 + `FRAME_BITS`, or is never reached, `len_match` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; input sampled on the rising edge, output driven on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next device in the chain |
| fr_we | output | 1 | Frame-data write strobe for the local store |
| fr_bit | output | 1 | Frame data bit to write |
| fr_idx | output | $clog2(FRAME_BITS) | Position of the frame bit in the local store |
| len_match | output | 1 | Clock count equals the captured total with the store full |

## Verification
The last frame write and the rise of `len_match` can fall in the same cycle. This happens when the captured total equals exactly the header length plus `FRAME_BITS`. The bench sweeps the total across that point: one below it, equal to it, just above it, and far beyond it (with the count's top bit set). It does this behind several prefixes: no lead-in, runs of leading ones, a broken pattern, and zeros. Each sample checks the strobe, the index and the match together against a position-based model. On the boundary total, `fr_we` with index `FRAME_BITS`-1 and `len_match` must be seen high in the same sample. One total lower must never match.

// File: rtl/chain_hdr_pkg.sv
package chain_hdr_pkg;

    localparam int           PRE_W    = 12;
    localparam logic [11:0]  PREAMBLE = 12'b1111_1111_0010;
    localparam int           LEN_W    = 24;
    localparam int           HDR_BITS = PRE_W + LEN_W;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_LOAD,
        ST_FULL,
        ST_DONE
    } phase_e;

    typedef struct packed {
        logic absorb;
        logic bit_v;
    } lane_t;

    function automatic logic is_preamble(input logic [PRE_W-1:0] w);
        return w == PREAMBLE;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chain_hdr_detect.sv
module chain_hdr_detect
    import chain_hdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic hunting,
    output logic found
);

    logic [PRE_W-2:0] win;

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else begin
            win <= {win[PRE_W-3:0], din};
        end
    end

    assign found = hunting && is_preamble({win, din});

    AST_FOUND_LAST_ZERO: assert property (@(posedge clk) disable iff (rst)
        found |-> !din);                                     // R2
    AST_FOUND_LEAVES_HUNT: assert property (@(posedge clk) disable iff (rst)
        found |=> !hunting);                                 // R2

endmodule

// File: rtl/chain_hdr_seq.sv
module chain_hdr_seq
    import chain_hdr_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          din,
    input  logic                          found,
    output logic                          hunting,
    output logic                          absorb,
    output logic                          fr_we,
    output logic                          fr_bit,
    output logic [$clog2(FRAME_BITS)-1:0] fr_idx,
    output logic                          len_match
);

    localparam int IDX_W   = $clog2(FRAME_BITS);
    localparam int SUB_MAX = max_i(FRAME_BITS, LEN_W);
    localparam int SUB_W   = $clog2(SUB_MAX);

    phase_e            phase;
    logic [LEN_W-1:0]  clk_cnt;
    logic [LEN_W-1:0]  len_q;
    logic [SUB_W-1:0]  sub;
    logic              cmp_hit;

    assign cmp_hit   = (phase == ST_FULL) && (clk_cnt == len_q);
    assign len_match = cmp_hit || (phase == ST_DONE);
    assign hunting   = (phase == ST_HUNT);
    assign absorb    = (phase == ST_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_HUNT;
            clk_cnt <= '0;
            len_q   <= '0;
            sub     <= '0;
            fr_we   <= 1'b0;
            fr_bit  <= 1'b0;
            fr_idx  <= '0;
        end else begin
            fr_we <= 1'b0;
            unique case (phase)
                ST_HUNT: begin
                    if (found) begin
                        phase   <= ST_LEN;
                        clk_cnt <= LEN_W'(PRE_W);
                        sub     <= '0;
                    end
                end
                ST_LEN: begin
                    len_q   <= {len_q[LEN_W-2:0], din};
                    clk_cnt <= clk_cnt + LEN_W'(1);
                    if (sub == SUB_W'(LEN_W - 1)) begin
                        phase <= ST_LOAD;
                        sub   <= '0;
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                ST_LOAD: begin
                    fr_we   <= 1'b1;
                    fr_bit  <= din;
                    fr_idx  <= sub[IDX_W-1:0];
                    clk_cnt <= clk_cnt + LEN_W'(1);
                    if (sub == SUB_W'(FRAME_BITS - 1)) begin
                        phase <= ST_FULL;
                        sub   <= '0;
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                ST_FULL: begin
                    if (cmp_hit) begin
                        phase <= ST_DONE;
                    end else begin
                        clk_cnt <= clk_cnt + LEN_W'(1);
                    end
                end
                ST_DONE: begin
                    phase <= ST_DONE;
                end
                default: phase <= ST_HUNT;
            endcase
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        fr_we |-> (fr_idx <= IDX_W'(FRAME_BITS - 1)));                     // R5
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (fr_we && fr_idx != '0) |-> ($past(fr_we) &&
            fr_idx == IDX_W'($past(fr_idx) + IDX_W'(1))));                 // R5
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        len_match |=> len_match);                                          // R8
    AST_MATCH_LAST: assert property (@(posedge clk) disable iff (rst)
        len_match |-> (!fr_we || fr_idx == IDX_W'(FRAME_BITS - 1)));       // R7
    AST_NO_WRITE_AFTER: assert property (@(posedge clk) disable iff (rst)
        len_match |=> !fr_we);                                             // R6

endmodule

// File: rtl/chain_hdr_dout.sv
module chain_hdr_dout
    import chain_hdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic absorb,
    output logic dout
);

    lane_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{absorb: 1'b0, bit_v: 1'b1};
        end else begin
            q <= '{absorb: absorb, bit_v: din};
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            dout <= 1'b1;
        end else begin
            dout <= q.absorb | q.bit_v;
        end
    end

    AST_HOLD_HIGH: assert property (@(negedge clk) disable iff (rst)
        q.absorb |=> dout);                                  // R5
    AST_PASS_BIT: assert property (@(negedge clk) disable iff (rst)
        !q.absorb |=> (dout == $past(q.bit_v)));             // R4

endmodule

// File: rtl/chain_hdr_rx.sv
module chain_hdr_rx
    import chain_hdr_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          din,
    output logic                          dout,
    output logic                          fr_we,
    output logic                          fr_bit,
    output logic [$clog2(FRAME_BITS)-1:0] fr_idx,
    output logic                          len_match
);

    logic hunting;
    logic found;
    logic absorb;

    chain_hdr_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .hunting (hunting),
        .found   (found)
    );

    chain_hdr_seq #(
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .found     (found),
        .hunting   (hunting),
        .absorb    (absorb),
        .fr_we     (fr_we),
        .fr_bit    (fr_bit),
        .fr_idx    (fr_idx),
        .len_match (len_match)
    );

    chain_hdr_dout u_dout (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .absorb (absorb),
        .dout   (dout)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!fr_we && !len_match));              // R1

endmodule

// File: tb/chain_hdr_rx_test.sv
module chain_hdr_rx_test;

    localparam int F     = 16;
    localparam int IDX_W = $clog2(F);
    localparam int HDR   = 36;
    localparam int MAXS  = 256;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             din = 1'b1;
    logic             dout;
    logic             fr_we;
    logic             fr_bit;
    logic [IDX_W-1:0] fr_idx;
    logic             len_match;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic s [MAXS];
    int   slen;
    int   pre_at;

    always #4 clk = ~clk;

    chain_hdr_rx #(.FRAME_BITS(F)) uut (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .dout      (dout),
        .fr_we     (fr_we),
        .fr_bit    (fr_bit),
        .fr_idx    (fr_idx),
        .len_match (len_match)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic b);
        s[slen] = b;
        slen++;
    endtask

    // kind 0: nothing, 1: leading ones, 2: broken pattern, 3: zeros
    task automatic build(input int kind, input int lead, input int lenv,
                         input int seed, input int extra);
        slen = 0;
        case (kind)
            1: for (int i = 0; i < lead; i++) push(1'b1);
            2: begin
                for (int i = 0; i < 8; i++) push(1'b1);
                push(1'b0); push(1'b0); push(1'b1); push(1'b1);
            end
            3: for (int i = 0; i < lead; i++) push(1'b0);
            default: ;
        endcase
        pre_at = slen;
        for (int i = 11; i >= 0; i--) push(logic'((12'hFF2 >> i) & 1));
        for (int i = 23; i >= 0; i--) push(logic'((lenv >> i) & 1));
        for (int j = 0; j < F; j++) push(logic'(((j * 5 + seed) >> 1) & 1));
        for (int j = 0; j < extra; j++) push(logic'(((j * 3 + seed) >> 2) & 1));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        din = 1'b1;
        repeat (3) @(posedge clk);
        #7;
        chk(dout == 1'b1, "R1", "dout in reset", int'(dout), 1);
        chk(fr_we == 1'b0, "R1", "fr_we in reset", int'(fr_we), 0);
        chk(len_match == 1'b0, "R1", "len_match in reset", int'(len_match), 0);
        rst = 1'b0;
    endtask

    task automatic run(input int kind, input int lead, input int lenv,
                       input int seed, input int extra);
        int  p;
        bit  we_e;
        bit  m_e;
        bit  d_e;
        bit  saw_both;
        string rq;
        build(kind, lead, lenv, seed, extra);
        do_reset();
        saw_both = 1'b0;
        for (int i = 0; i < slen; i++) begin
            din = s[i];
            @(posedge clk);
            #7;
            p    = i - pre_at;
            we_e = (p >= HDR) && (p < HDR + F);
            d_e  = we_e ? 1'b1 : s[i];
            m_e  = (lenv >= HDR + F) && (p + 1 >= lenv);
            if (p < HDR)       rq = "R4";
            else if (we_e)     rq = "R5";
            else               rq = "R6";
            chk(dout == d_e, rq, "dout", int'(dout), int'(d_e));
            chk(fr_we == we_e, (p < HDR) ? "R2" : rq, "fr_we",
                int'(fr_we), int'(we_e));
            if (we_e) begin
                chk(fr_bit == s[i], "R5", "fr_bit", int'(fr_bit), int'(s[i]));
                chk(int'(fr_idx) == p - HDR, "R5", "fr_idx",
                    int'(fr_idx), p - HDR);
            end
            chk(len_match == m_e, (p + 1 > lenv) ? "R8" : "R7/R3",
                "len_match", int'(len_match), int'(m_e));
            if (fr_we && len_match) saw_both = 1'b1;
        end
        if (lenv == HDR + F)
            chk(saw_both, "R7", "write and match same cycle", int'(saw_both), 1);
    endtask

    initial begin
        int lens [5];
        lens[0] = HDR + F - 1;
        lens[1] = HDR + F;
        lens[2] = HDR + F + 1;
        lens[3] = HDR + F + 5;
        lens[4] = 24'h800000 + HDR + F;
        for (int k = 0; k < 4; k++) begin
            for (int l = 0; l < 5; l++) begin
                run(k, k + 2, lens[l], k * 7 + l, 12);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule